// File: doc/BRIEF.md
# Radix-16 Iterative Multiply-Accumulator

This block forms a 16 x 16 product by retiring one 4-bit digit of the multiplier per clock. It uses a single 48-bit accumulator. The multiplier is parked in the low half of the accumulator, and the digit consumed on each step is read from its four lowest bits. The partial product of that digit and a 24-bit multiplicand is added into the upper half. The register then moves right by four places, so the vacated low bits drop out and the next digit comes into position.

A load strobe starts a multiply. It writes the multiplier into the accumulator and fixes the arithmetic mode for the whole run. After that, four step pulses finish the job. The step pulses need not be back to back, because the block simply waits while no step is requested. The multiplicand is sampled on every step, so the operand source must hold it steady for the whole run.

When the run ends, bits [47:8] hold the full 40-bit product of the 24-bit multiplicand and the 16-bit multiplier. This means bits [39:8] carry the 16 x 16 result whenever the multiplicand is a 16-bit value extended to 24 bits. The lowest eight bits hold whatever remains of the extended multiplier.

Top module: `radix16_mac`

## Requirements
- R1: After reset, `acc_o` is zero and `busy_o` and `done_o` are low.
- R2: A cycle with `load_i` high sets the accumulator to 24 zero bits above `mplr_i`, which is extended to 24 bits. The extension copies `mplr_i[15]` when `signed_i` is high and uses zeros otherwise. The same cycle raises `busy_o` and leaves `done_o` low.
- R3: Each accepted step forms a 28-bit partial product from the digit `acc[3:0]` and the multiplicand. It adds that product to the upper 24 accumulator bits, widened to 28 bits. The new accumulator is that 28-bit sum placed above the old bits [23:4].
- R4: `done_o` is high for exactly one cycle, directly after the fourth accepted step. In that same cycle `busy_o` returns low.
- R5: In unsigned mode, after the fourth step, `acc_o[47:8]` equals the unsigned product of `mcand_i` and `mplr_i`, and `acc_o[7:0]` is zero.
- R6: In signed mode, the multiplicand is treated as a 24-bit two's-complement value and the fourth digit is treated as signed (-8..7). After the fourth step, `acc_o[47:8]` equals the 40-bit two's-complement product, and `acc_o[7:0]` repeats `mplr_i[15]`.
- R7: A `step_i` pulse while `busy_o` is low leaves `acc_o` unchanged.
- R8: When `load_i` and `step_i` are both high in the same cycle, the load wins. The accumulator takes the load value and the step count restarts.
- R9: During a run, a cycle without `step_i` leaves `acc_o` and the step count unchanged.
- R10: The mode comes from `signed_i` only in the load cycle. Changing `signed_i` during a run does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a multiply with `mplr_i` |
| signed_i | input | 1 | Two's-complement mode, taken at load |
| mplr_i | input | 16 | Multiplier value |
| mcand_i | input | 24 | Multiplicand, sampled on each step |
| step_i | input | 1 | Retire one digit during a run |
| acc_o | output | 48 | Accumulator contents |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle flag after the last step |

## Verification
Two functions can fall in the same cycle: a new load and a digit step. The bench provokes this by asserting `load_i` and `step_i` together in the middle of a run. It then checks that the accumulator holds the fresh load value, and that four further steps give the product of the new operands. A second overlap sets the mode input to the opposite value right after load while steps are retiring. The final result must still match the mode captured at load. A sweep over multiplier and multiplicand corners in both modes, with and without idle gaps between steps, compares every final accumulator against a product computed arithmetically.

// File: rtl/r16_pkg.sv
package r16_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;

  // extend a narrow value to a wider field, optionally copying its sign
  function automatic logic [23:0] widen16to24(input logic [15:0] v, input logic sgn);
    widen16to24 = {{8{sgn & v[15]}}, v};
  endfunction
endpackage

// File: rtl/r16_digit_mul.sv
module r16_digit_mul #(
  parameter int DIGIT_W = 4,
  parameter int MCAND_W = 24,
  localparam int PP_W = DIGIT_W + MCAND_W
) (
  input  logic [DIGIT_W-1:0] digit,
  input  logic               digit_signed,
  input  logic [MCAND_W-1:0] mcand,
  input  logic               mcand_signed,
  output logic [PP_W-1:0]    pp
);
  logic signed [DIGIT_W:0] d_ext;
  logic signed [MCAND_W:0] m_ext;
  logic signed [PP_W-1:0]  prod;

  always_comb begin
    d_ext = {digit_signed & digit[DIGIT_W-1], digit};
    m_ext = {mcand_signed & mcand[MCAND_W-1], mcand};
    // low PP_W bits of the product are exact modulo 2**PP_W
    prod  = PP_W'(d_ext) * PP_W'(m_ext);
    pp    = prod;
  end
endmodule

// File: rtl/r16_acc_next.sv
module r16_acc_next #(
  parameter int DIGIT_W = 4,
  parameter int HALF_W  = 24,
  localparam int PP_W  = DIGIT_W + HALF_W,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0]        upper,
  input  logic [HALF_W-DIGIT_W-1:0] lower_keep,
  input  logic [PP_W-1:0]          pp,
  input  logic                     signed_mode,
  output logic [ACC_W-1:0]         acc_nxt
);
  logic [PP_W-1:0] upper_ext;
  logic [PP_W-1:0] sum;

  always_comb begin
    upper_ext = {{DIGIT_W{signed_mode & upper[HALF_W-1]}}, upper};
    sum       = upper_ext + pp;
    acc_nxt   = {sum, lower_keep};
  end
endmodule

// File: rtl/r16_seq.sv
module r16_seq
  import r16_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic busy,
  output logic done,
  output logic last,
  output logic advance
);
  run_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  always_comb begin
    last    = (cnt_q == CNT_W'(STEPS - 1));
    advance = (state_q == RUN_BUSY) & step & ~load;
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load) begin
      state_d = RUN_BUSY;
      cnt_d   = '0;
    end else if (advance) begin
      if (last) begin
        state_d = RUN_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == RUN_BUSY);
  assign done = done_q;
endmodule

// File: rtl/radix16_mac.sv
module radix16_mac
  import r16_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int MPLR_W  = 16,
  parameter int MCAND_W = 24,
  localparam int HALF_W = MCAND_W,
  localparam int ACC_W  = 2 * MCAND_W,
  localparam int PP_W   = DIGIT_W + MCAND_W,
  localparam int STEPS  = MPLR_W / DIGIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               signed_i,
  input  logic [MPLR_W-1:0]  mplr_i,
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic               step_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [ACC_W-1:0] acc_q, acc_d, acc_step, acc_load;
  logic             mode_q, mode_d;
  logic             last, advance;
  logic [PP_W-1:0]  pp;
  logic [HALF_W-1:0] mplr_ext;

  r16_seq #(.STEPS(STEPS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_i),
    .step   (step_i),
    .busy   (busy_o),
    .done   (done_o),
    .last   (last),
    .advance(advance)
  );

  r16_digit_mul #(.DIGIT_W(DIGIT_W), .MCAND_W(MCAND_W)) u_mul (
    .digit       (acc_q[DIGIT_W-1:0]),
    .digit_signed(mode_q & last),
    .mcand       (mcand_i),
    .mcand_signed(mode_q),
    .pp          (pp)
  );

  r16_acc_next #(.DIGIT_W(DIGIT_W), .HALF_W(HALF_W)) u_next (
    .upper      (acc_q[ACC_W-1:HALF_W]),
    .lower_keep (acc_q[HALF_W-1:DIGIT_W]),
    .pp         (pp),
    .signed_mode(mode_q),
    .acc_nxt    (acc_step)
  );

  generate
    if (HALF_W > MPLR_W) begin : g_ext
      assign mplr_ext = {{(HALF_W-MPLR_W){signed_i & mplr_i[MPLR_W-1]}}, mplr_i};
    end else begin : g_noext
      assign mplr_ext = mplr_i[HALF_W-1:0];
    end
  endgenerate

  always_comb begin
    acc_load = {{HALF_W{1'b0}}, mplr_ext};
    acc_d    = acc_q;
    mode_d   = mode_q;
    if (load_i) begin
      acc_d  = acc_load;
      mode_d = signed_i;
    end else if (advance) begin
      acc_d  = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mode_q <= mode_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/radix16_mac_chk.sv
module radix16_mac_chk #(
  parameter int ACC_W  = 48,
  parameter int HALF_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             step_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             busy_o,
  input logic             done_o
);
  // R2
  load_clears_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_o[ACC_W-1:HALF_W] == '0) && busy_o && !done_o);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  idle_step_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> $stable(acc_o) && !busy_o);

  // R9
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i && !load_i) |=> $stable(acc_o) && busy_o && !done_o);
endmodule

bind radix16_mac radix16_mac_chk #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .load_i(load_i),
  .step_i(step_i),
  .acc_o (acc_o),
  .busy_o(busy_o),
  .done_o(done_o)
);

// File: tb/sim_radix16_mac.sv
module sim_radix16_mac;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [15:0] mplr_i = '0;
  logic [23:0] mcand_i = '0;
  logic        step_i = 1'b0;
  logic [47:0] acc_o;
  logic        busy_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix16_mac u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .signed_i(signed_i),
    .mplr_i(mplr_i), .mcand_i(mcand_i), .step_i(step_i),
    .acc_o(acc_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_final(input logic [15:0] m, input logic [23:0] mc, input bit s);
    longint p;
    if (s) p = longint'($signed(mc)) * longint'($signed(m));
    else   p = longint'(mc) * longint'(m);
    return {p[39:0], (s ? {8{m[15]}} : 8'h00)};
  endfunction

  function automatic logic [15:0] pick_mplr(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return 16'h8000;  4: return 16'h7FFF;  5: return 16'h000F;
      6: return 16'hF000;  7: return 16'h0008;
      default: return 16'(i * 16'h1357) ^ 16'(i << 9);
    endcase
  endfunction

  function automatic logic [23:0] pick_mcand(input int i);
    case (i)
      0: return 24'h000000;  1: return 24'h000001;  2: return 24'hFFFFFF;
      3: return 24'h800000;  4: return 24'h7FFFFF;  5: return 24'hFFFF80;
      default: return 24'(i * 24'h2D4B1F) ^ 24'(i << 17);
    endcase
  endfunction

  task automatic do_load(input logic [15:0] m, input bit s, input logic [23:0] mc);
    load_i = 1'b1; mplr_i = m; signed_i = s; mcand_i = mc;
    @(negedge clk);
    load_i = 1'b0;
    chk("R2 load value", acc_o, {24'h0, (s ? {8{m[15]}} : 8'h00), m});
    chk("R2 busy/done", {46'h0, busy_o, done_o}, 48'h2);
  endtask

  task automatic run_mul(input logic [15:0] m, input logic [23:0] mc, input bit s, input bit gaps);
    logic [47:0] held;
    do_load(m, s, mc);
    signed_i = ~s;  // R10: mode input toggled mid-run must be ignored
    for (int k = 0; k < 4; k++) begin
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      if (k == 3) begin
        chk(s ? "R6 signed product" : "R5 unsigned product", acc_o, exp_final(m, mc, s));
        chk("R4 done after fourth step", {46'h0, busy_o, done_o}, 48'h1);
      end else begin
        chk("R4 no early done", {47'h0, done_o}, 48'h0);
        if (gaps) begin
          held = acc_o;
          @(negedge clk);
          chk("R9 hold without step", acc_o, held);
        end
      end
    end
    @(negedge clk);
    chk("R4 done one cycle", {47'h0, done_o}, 48'h0);
    held = acc_o;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    chk("R7 idle step ignored", acc_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1
    chk("R1 reset acc", acc_o, 48'h0);
    chk("R1 reset flags", {46'h0, busy_o, done_o}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single steps with known partial sums
    do_load(16'h0003, 1'b0, 24'h000005);
    step_i = 1'b1; @(negedge clk); step_i = 1'b0;
    chk("R3 unsigned step", acc_o, 48'h000000F00000);
    do_load(16'h0001, 1'b1, 24'hFFFFFF);
    step_i = 1'b1; @(negedge clk); step_i = 1'b0;
    chk("R3 signed step", acc_o, 48'hFFFFFFF00000);

    // R8: load and step together in mid-run
    do_load(16'h1234, 1'b0, 24'h00ABCD);
    step_i = 1'b1; repeat (2) @(negedge clk);
    load_i = 1'b1; mplr_i = 16'hBEEF; signed_i = 1'b1; mcand_i = 24'hF00F0F;
    @(negedge clk);
    load_i = 1'b0;
    chk("R8 load wins over step", acc_o, {24'h0, 8'hFF, 16'hBEEF});
    repeat (3) @(negedge clk);
    chk("R8 no early done after restart", {47'h0, done_o}, 48'h0);
    @(negedge clk);
    step_i = 1'b0;
    chk("R8 product of new operands", acc_o, exp_final(16'hBEEF, 24'hF00F0F, 1'b1));
    chk("R8 done after restart", {46'h0, busy_o, done_o}, 48'h1);
    @(negedge clk);

    // R5 R6 R9 R10 sweep
    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 16; j++)
        for (int s = 0; s < 2; s++)
          run_mul(pick_mplr(i), pick_mcand(j), s[0], ((i + j) % 3) == 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule